// File: doc/BRIEF.md
# Multi-mode four-input function generator

This block is a small configurable logic cell built around one 16-bit storage word and four select inputs. The same word can act in three ways. As a lookup table, the four inputs pick one bit of a truth table, so any Boolean function of four variables can be realised. As a 16-entry by 1-bit memory, writes are synchronous and reads are combinational. As a 16-stage shift register, the select inputs choose which stage appears at the output.

A two-bit mode input chooses the personality. A wide load port replaces the whole word in one clock, and it takes priority over any write or shift in that cycle. The selected bit leaves the cell on a direct combinational output. The same bit also feeds a companion flip-flop, so the cell can drive a registered output as well. The last stage of the word is always visible on a cascade output, which lets several cells form longer shift chains.

The read path is a balanced tree of 2:1 multiplexers. The delay from the select inputs to the output is therefore the same for every programmed function and in every mode.

Top module: `fgen_cell`

## Requirements
- R1: When `rst` is high at a rising edge, the storage word, `q_o` and `shift_out_o` all become 0, and `f_o` reads 0 at every address.
- R2: When `cfg_load_i` is high at a rising edge, all 16 storage bits take `cfg_data_i`. After that edge, `f_o` equals `cfg_data_i[addr_i]`, where bit k is selected by `addr_i == k`.
- R3: In lookup mode (`mode_i == 2'b00`), `we_i` and `din_i` have no effect. The word changes only through the load port or reset.
- R4: In memory mode (`mode_i == 2'b01`), a rising edge with `we_i` high writes `din_i` into bit `addr_i` and leaves the other 15 bits unchanged.
- R5: `f_o` is a combinational function of the word and `addr_i`. A change on `addr_i` with no clock edge shows up on `f_o` at once.
- R6: In shift mode (`mode_i == 2'b10`), a rising edge with `we_i` high moves each bit k into bit k+1 and loads `din_i` into bit 0. With `we_i` low, the word holds.
- R7: `shift_out_o` always equals bit 15 of the word.
- R8: A load in the same cycle as a memory write or a shift wins, and the write or shift is discarded.
- R9: `q_o` takes the value `f_o` had just before each rising edge, so it lags `f_o` by one cycle.
- R10: The reserved mode value `2'b11` behaves like lookup mode: `we_i` does not change the word.
- R11: Reset takes priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Personality: 00 lookup, 01 memory, 10 shift, 11 reserved (acts as lookup) |
| we_i | input | 1 | Write enable in memory mode, shift enable in shift mode |
| din_i | input | 1 | Data bit to write, or serial bit to shift in |
| addr_i | input | 4 | Select inputs: truth-table index, memory address or tap number |
| cfg_load_i | input | 1 | Loads the whole word from `cfg_data_i` |
| cfg_data_i | input | 16 | Contents to load |
| f_o | output | 1 | Selected bit, combinational |
| q_o | output | 1 | Selected bit, registered |
| shift_out_o | output | 1 | Bit 15 of the word, used to cascade cells |

## Verification
The bench attacks the priority corners. These are a load that coincides with a write or a shift, which would corrupt one bit if the write won, and reset together with a load, which would leave the loaded pattern in place. It drives `we_i` high in lookup mode and in the reserved mode, where a decoder that only checked one mode bit would let writes through and change the truth table. It runs a single set bit along all sixteen stages to catch off-by-one tap or shift wiring. It also sweeps the address between clock edges, so that a registered read would return stale bits.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    localparam int SEL_W = 4;
    localparam int DEPTH = 1 << SEL_W;

    typedef enum logic [1:0] {
        FG_LUT   = 2'd0,
        FG_RAM   = 2'd1,
        FG_SHIFT = 2'd2,
        FG_RSVD  = 2'd3
    } fg_mode_e;

    // Decoded update operation for one clock edge
    typedef struct packed {
        logic load;
        logic wr;
        logic sh;
    } fg_op_s;

    function automatic fg_op_s fg_decode(input logic [1:0] mode,
                                         input logic       we,
                                         input logic       load);
        fg_op_s op;
        op.load = load;
        op.wr   = !load && (fg_mode_e'(mode) == FG_RAM)   && we;
        op.sh   = !load && (fg_mode_e'(mode) == FG_SHIFT) && we;
        return op;
    endfunction

endpackage

// File: rtl/fgen_store.sv
module fgen_store
    import fgen_pkg::*;
#(
    parameter int SEL_W = fgen_pkg::SEL_W,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  fg_op_s           op,
    input  logic [SEL_W-1:0] addr,
    input  logic             din,
    input  logic [DEPTH-1:0] cfg_data,
    output logic [DEPTH-1:0] word_q
);

    // One slice of update logic per storage bit
    for (genvar k = 0; k < DEPTH; k++) begin : g_bit
        logic nxt;
        logic shift_src;

        if (k == 0) begin : g_head
            assign shift_src = din;
        end else begin : g_body
            assign shift_src = word_q[k-1];
        end

        always_comb begin
            if (op.load) begin
                nxt = cfg_data[k];
            end else if (op.wr && (addr == SEL_W'(k))) begin
                nxt = din;
            end else if (op.sh) begin
                nxt = shift_src;
            end else begin
                nxt = word_q[k];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[k] <= 1'b0;
            end else begin
                word_q[k] <= nxt;
            end
        end
    end

endmodule

// File: rtl/fgen_tap.sv
module fgen_tap #(
    parameter int SEL_W = fgen_pkg::SEL_W,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic [DEPTH-1:0] data_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    // Balanced 2:1 tree: every path crosses SEL_W mux levels
    for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
        localparam int N = DEPTH >> (l + 1);
        logic [N-1:0]   node;
        logic [2*N-1:0] src;

        if (l == 0) begin : g_src_first
            assign src = data_i;
        end else begin : g_src_next
            assign src = g_lvl[l-1].node;
        end

        for (genvar i = 0; i < N; i++) begin : g_mux
            assign node[i] = sel_i[l] ? src[2*i+1] : src[2*i];
        end
    end

    assign bit_o = g_lvl[SEL_W-1].node[0];

endmodule

// File: rtl/fgen_oreg.sv
module fgen_oreg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/fgen_cell.sv
module fgen_cell
    import fgen_pkg::*;
#(
    parameter int SEL_W = fgen_pkg::SEL_W,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             we_i,
    input  logic             din_i,
    input  logic [SEL_W-1:0] addr_i,
    input  logic             cfg_load_i,
    input  logic [DEPTH-1:0] cfg_data_i,
    output logic             f_o,
    output logic             q_o,
    output logic             shift_out_o
);

    fg_op_s           op;
    logic [DEPTH-1:0] store_q;

    assign op = fg_decode(mode_i, we_i, cfg_load_i);

    fgen_store #(.SEL_W(SEL_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .addr     (addr_i),
        .din      (din_i),
        .cfg_data (cfg_data_i),
        .word_q   (store_q)
    );

    fgen_tap #(.SEL_W(SEL_W)) u_tap (
        .data_i (store_q),
        .sel_i  (addr_i),
        .bit_o  (f_o)
    );

    fgen_oreg u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (f_o),
        .q   (q_o)
    );

    assign shift_out_o = store_q[DEPTH-1];

endmodule

// File: rtl/fgen_cell_chk.sv
module fgen_cell_chk
    import fgen_pkg::*;
#(
    parameter int SEL_W = fgen_pkg::SEL_W,
    localparam int DEPTH = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic             we_i,
    input logic             din_i,
    input logic [SEL_W-1:0] addr_i,
    input logic             cfg_load_i,
    input logic [DEPTH-1:0] cfg_data_i,
    input logic [DEPTH-1:0] word_q,
    input logic             f_o,
    input logic             q_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (word_q == '0) && !q_o); // R1

    AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
        cfg_load_i |=> word_q == $past(cfg_data_i)); // R8

    AST_LUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && (mode_i == 2'b00)) |=> $stable(word_q)); // R3

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && (mode_i == 2'b11)) |=> $stable(word_q)); // R10

    AST_RAM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && (mode_i == 2'b01) && we_i) |=> word_q[$past(addr_i)] == $past(din_i)); // R4

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && (mode_i == 2'b10) && we_i) |=> word_q[0] == $past(din_i)); // R6

    AST_QREG_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q_o == $past(f_o)); // R9

endmodule

bind fgen_cell fgen_cell_chk #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .we_i       (we_i),
    .din_i      (din_i),
    .addr_i     (addr_i),
    .cfg_load_i (cfg_load_i),
    .cfg_data_i (cfg_data_i),
    .word_q     (store_q),
    .f_o        (f_o),
    .q_o        (q_o)
);

// File: tb/fgen_cell_tb.sv
`timescale 1ns/1ps
module fgen_cell_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        we = 1'b0;
    logic        din = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_data = 16'h0;
    logic        f_o, q_o, shift_out;

    logic [15:0] exp_mem = 16'h0;
    logic        exp_q = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    fgen_cell u_dut (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .we_i        (we),
        .din_i       (din),
        .addr_i      (addr),
        .cfg_load_i  (cfg_load),
        .cfg_data_i  (cfg_data),
        .f_o         (f_o),
        .q_o         (q_o),
        .shift_out_o (shift_out)
    );

    // Reference update rule from the requirements
    function automatic logic [15:0] model_next(input logic [15:0] m, input logic r,
        input logic [1:0] md, input logic w, input logic d, input logic [3:0] a,
        input logic l, input logic [15:0] c);
        logic [15:0] n = m;
        if (r)                      n = 16'h0;
        else if (l)                 n = c;
        else if (md == 2'b01 && w)  n[a] = d;
        else if (md == 2'b10 && w)  n = {m[14:0], d};
        return n;
    endfunction

    task automatic chk(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Drive one cycle starting at a falling edge, check at the next falling edge
    task automatic cyc(input logic r, input logic [1:0] md, input logic w, input logic d,
                       input logic [3:0] a, input logic l, input logic [15:0] c,
                       input string tag);
        logic qn;
        rst = r; mode = md; we = w; din = d; addr = a; cfg_load = l; cfg_data = c;
        @(posedge clk);
        qn      = r ? 1'b0 : exp_mem[a];
        exp_mem = model_next(exp_mem, r, md, w, d, a, l, c);
        exp_q   = qn;
        @(negedge clk);
        chk(tag, f_o, exp_mem[a]);
        chk("R7", shift_out, exp_mem[15]);
        chk("R9", q_o, exp_q);
    endtask

    // Address sweep without writes; samples land between clock edges
    task automatic sweep(input string tag);
        we = 1'b0; cfg_load = 1'b0; rst = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #2;
            chk(tag, f_o, exp_mem[a]);
            #6;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        logic [1:0] md;
        logic w, d, l;
        void'($urandom(32'd4177));
        @(negedge clk);

        // R1: reset state
        cyc(1'b1, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0, "R1");
        chk("R1", q_o, 1'b0);
        chk("R1", shift_out, 1'b0);
        sweep("R1");

        // R2: full load, then every index
        cyc(1'b0, 2'b00, 1'b0, 1'b0, 4'd3, 1'b1, 16'hA5C3, "R2");
        sweep("R2");

        // R3: enable toggling in lookup mode does nothing
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 2'b00, 1'b1, 1'(i), 4'(i * 5), 1'b0, 16'h0, "R3");
        sweep("R3");

        // R10: reserved mode likewise
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 2'b11, 1'b1, 1'(~i), 4'(i * 3), 1'b0, 16'h0, "R10");
        sweep("R10");

        // R4: memory writes, then R5 combinational read-back
        cyc(1'b0, 2'b01, 1'b1, 1'b0, 4'd0, 1'b0, 16'h0, "R4");
        cyc(1'b0, 2'b01, 1'b1, 1'b1, 4'd4, 1'b0, 16'h0, "R4");
        cyc(1'b0, 2'b01, 1'b1, 1'b1, 4'd15, 1'b0, 16'h0, "R4");
        cyc(1'b0, 2'b01, 1'b0, 1'b0, 4'd15, 1'b0, 16'h0, "R4");
        sweep("R5");

        // R8: load collides with a write, then with a shift
        cyc(1'b0, 2'b01, 1'b1, 1'b1, 4'd0, 1'b1, 16'h0F0E, "R8");
        sweep("R8");
        cyc(1'b0, 2'b10, 1'b1, 1'b1, 4'd0, 1'b1, 16'h0001, "R8");
        sweep("R8");

        // R6, R7: walk the single set bit to the last stage
        for (int i = 0; i < 15; i++)
            cyc(1'b0, 2'b10, 1'b1, 1'b0, 4'(i + 1), 1'b0, 16'h0, "R6");
        chk("R7", shift_out, 1'b1);
        cyc(1'b0, 2'b10, 1'b0, 1'b1, 4'd15, 1'b0, 16'h0, "R6");
        chk("R7", shift_out, 1'b1);
        cyc(1'b0, 2'b10, 1'b1, 1'b1, 4'd0, 1'b0, 16'h0, "R6");
        chk("R7", shift_out, 1'b0);
        sweep("R6");

        // R11: reset beats a load
        cyc(1'b1, 2'b00, 1'b0, 1'b0, 4'd7, 1'b1, 16'hFFFF, "R11");
        sweep("R11");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            md = 2'($urandom);
            w  = 1'($urandom);
            d  = 1'($urandom);
            l  = ($urandom % 10) == 0;
            if (l)                      tag = "R8";
            else if (md == 2'b01 && w)  tag = "R4";
            else if (md == 2'b10 && w)  tag = "R6";
            else if (md == 2'b11)       tag = "R10";
            else                        tag = "R3";
            cyc(1'b0, md, w, d, 4'($urandom), l, 16'($urandom), tag);
        end
        sweep("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule